// File: doc/BRIEF.md
# NAND command cycle sequencer

This block carries out one operation on a raw NAND flash bus: command latch, address latch, write strobe, read strobe, chip enable, an 8-bit data bus and the ready/busy line. Before starting, the surrounding logic presents a packed pair of command codes, a set of phase enables, an address-cycle count, a 32-bit address word with an 8-bit extension and a byte count. It then pulses `start`. The configuration is captured on that pulse. The sequencer then emits the enabled bus cycles in a fixed order and raises `done` once the flash reports ready.

An operation is not picked from a list of opcodes. It is assembled from independent switches: a first command cycle, an address phase, a second command cycle and a data phase whose direction is set by `data_write`. The switches cover the common cases:

- Reset and status: command only.
- Read-ID: command, one address byte, four data reads.
- Erase: command, address, command.
- Page program: command, address, data, command.
- Large-page read: command, address, command, wait for ready, data.

Write data comes from an external byte FIFO. Read data goes to a second external byte FIFO. Each data cycle stalls while its FIFO cannot serve it.

States:

- `ST_IDLE`: waiting for `start`.
- `ST_CMD1`: first command cycle.
- `ST_ADDR`: address cycles.
- `ST_CMD2`: second command cycle.
- `ST_RDY_PRE`: ready wait before read data.
- `ST_DATA`: data cycles.
- `ST_RDY_END`: final ready wait.

Transitions:

- `ST_IDLE` goes on `start` to the first enabled phase.
- `ST_CMD1` goes to `ST_ADDR`, or straight to the post-address choice.
- `ST_ADDR` leaves after its last byte.
- After the address phase, a write goes to `ST_DATA`, or to `ST_CMD2` when the count is zero, or to `ST_RDY_END`. A read goes to `ST_CMD2`, or to `ST_DATA` when the second command is off, or to `ST_RDY_END`.
- `ST_CMD2` goes to `ST_RDY_PRE` for a read with data, and to `ST_RDY_END` otherwise.
- `ST_RDY_PRE` goes to `ST_DATA`.
- `ST_DATA` goes, after its last byte, to `ST_CMD2` for a write with the second command enabled, and to `ST_RDY_END` otherwise.
- `ST_RDY_END` goes to `ST_IDLE` and sets `done`.

Top module: `nand_op_seq`

## Requirements
- R1: A command cycle drives CLE high, ALE low and the data bus enabled. The first command code is `cmd_codes[7:0]` and the second is `cmd_codes[15:8]`.
- R2: A phase whose enable is low produces no bus cycle. The other enabled phases still run in order.
- R3: The address phase emits exactly the capped `addr_cycles` count of cycles with ALE high. Bytes come least-significant first from `{addr_ext, addr_word}`: bytes 0 to 3 are `addr_word[7:0]` through `addr_word[31:24]`, and byte 4 is `addr_ext`.
- R4: With `large_page` low the address count is capped at 4. With `large_page` high it is capped at 5.
- R5: With `data_write` high the data bytes come before the second command. With it low the second command comes before the data reads.
- R6: The data phase moves exactly `data_count` bytes. A count of zero produces no data cycle.
- R7: In a read whose second command is followed by data, the read strobe does not go low until `BUSY_DLY` cycles have passed and `nand_rb_n` is high.
- R8: `done` rises only after all cycles are issued and `nand_rb_n` is high. It holds until `done_clr` or the next accepted `start`. A `start` during an operation is ignored.
- R9: Each write or read strobe stays low for exactly `PULSE_CYC` cycles, and strobes are separated by at least `PULSE_CYC` high cycles. The two strobes are never low together.
- R10: `nand_ce_n` is the inverse of `chip_en` at all times.
- R11: Write bytes are taken in FIFO order, one pop per byte. No write-data strobe starts while `wf_empty` is high.
- R12: Each read byte is pushed with `rf_push` in its last strobe-low cycle, in bus order. No read strobe starts while `rf_full` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| start | input | 1 | begin an operation (accepted in idle) |
| done_clr | input | 1 | clear the done flag |
| cmd_codes | input | 16 | [7:0] first command, [15:8] second command |
| en_cmd1 | input | 1 | enable first command cycle |
| en_addr | input | 1 | enable address phase |
| en_cmd2 | input | 1 | enable second command cycle |
| data_write | input | 1 | data direction, 1 = write to flash |
| addr_cycles | input | 3 | requested address cycle count |
| large_page | input | 1 | permits a fifth address cycle |
| addr_word | input | 32 | address bytes 0..3 |
| addr_ext | input | 8 | address byte 4 |
| data_count | input | CNT_W | bytes in the data phase |
| chip_en | input | 1 | drives chip enable |
| done | output | 1 | operation complete flag |
| nand_ce_n | output | 1 | chip enable, active low |
| nand_cle | output | 1 | command latch enable |
| nand_ale | output | 1 | address latch enable |
| nand_we_n | output | 1 | write strobe, active low |
| nand_re_n | output | 1 | read strobe, active low |
| nand_dq_out | output | 8 | bus data driven |
| nand_dq_oe | output | 1 | bus output enable |
| nand_dq_in | input | 8 | bus data sampled |
| nand_rb_n | input | 1 | ready (1) / busy (0) |
| wf_rdata | input | 8 | write FIFO head byte |
| wf_empty | input | 1 | write FIFO empty |
| wf_pop | output | 1 | take head byte of write FIFO |
| rf_full | input | 1 | read FIFO full |
| rf_push | output | 1 | push a read byte |
| rf_wdata | output | 8 | read byte pushed |

## Verification
The hardest situation to reach is the read-side ready gate. The second command must be followed by a busy period that starts only after the flash has seen that command, and the data reads must then be held off until both the delay and the ready line allow. The bench models the flash by pulling ready/busy low for a chosen number of cycles each time it observes the second command code latched on the bus. It then flags any read strobe seen while busy. FIFO stalls are reached by holding the empty or full flag from before `start` until well after the address phase, and then checking that the first data strobe comes only after the release.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    localparam int BYTE_W    = 8;
    localparam int ADDR_MAXB = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD1,
        ST_ADDR,
        ST_CMD2,
        ST_RDY_PRE,
        ST_DATA,
        ST_RDY_END
    } seq_state_e;

    // phase that follows the address phase (or its absence)
    function automatic seq_state_e after_addr_phase(input logic wr,
                                                    input logic en2,
                                                    input logic has_data);
        if (wr)
            return has_data ? ST_DATA : (en2 ? ST_CMD2 : ST_RDY_END);
        else
            return en2 ? ST_CMD2 : (has_data ? ST_DATA : ST_RDY_END);
    endfunction

    function automatic seq_state_e after_cmd2_phase(input logic wr,
                                                    input logic has_data);
        if (!wr && has_data)
            return ST_RDY_PRE;
        return ST_RDY_END;
    endfunction

    function automatic seq_state_e after_data_phase(input logic wr,
                                                    input logic en2);
        if (wr && en2)
            return ST_CMD2;
        return ST_RDY_END;
    endfunction

endpackage

// File: rtl/nand_strobe_timer.sv
module nand_strobe_timer #(
    parameter int PULSE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic at_start,
    output logic strobe_low,
    output logic sample,
    output logic fin
);
    localparam int PERIOD = 2 * PULSE_CYC;
    localparam int TW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run)
            cnt <= '0;
        else if (cnt == TW'(PERIOD - 1))
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign at_start   = (cnt == '0);
    assign strobe_low = run && (cnt < TW'(PULSE_CYC));
    assign sample     = run && (cnt == TW'(PULSE_CYC - 1));
    assign fin        = run && (cnt == TW'(PERIOD - 1));

endmodule

// File: rtl/nand_ready_gate.sv
module nand_ready_gate #(
    parameter int BUSY_DLY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic rb_n,
    output logic ok
);
    localparam int DW = $clog2(BUSY_DLY + 1);

    logic [DW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run)
            cnt <= '0;
        else if (cnt != DW'(BUSY_DLY))
            cnt <= cnt + 1'b1;
    end

    assign ok = run && (cnt == DW'(BUSY_DLY)) && rb_n;

endmodule

// File: rtl/nand_addr_shifter.sv
module nand_addr_shifter
    import nand_seq_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic                        shift,
    input  logic [ADDR_MAXB*BYTE_W-1:0] din,
    output logic [BYTE_W-1:0]           dout
);
    localparam int SW = ADDR_MAXB * BYTE_W;

    logic [SW-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sh <= '0;
        else if (load)
            sh <= din;
        else if (shift)
            sh <= {{BYTE_W{1'b0}}, sh[SW-1:BYTE_W]};
    end

    assign dout = sh[BYTE_W-1:0];

endmodule

// File: rtl/nand_op_seq.sv
module nand_op_seq
    import nand_seq_pkg::*;
#(
    parameter int PULSE_CYC = 2,
    parameter int BUSY_DLY  = 3,
    parameter int CNT_W     = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              done_clr,
    input  logic [15:0]       cmd_codes,
    input  logic              en_cmd1,
    input  logic              en_addr,
    input  logic              en_cmd2,
    input  logic              data_write,
    input  logic [2:0]        addr_cycles,
    input  logic              large_page,
    input  logic [31:0]       addr_word,
    input  logic [7:0]        addr_ext,
    input  logic [CNT_W-1:0]  data_count,
    input  logic              chip_en,
    output logic              done,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [7:0]        nand_dq_out,
    output logic              nand_dq_oe,
    input  logic [7:0]        nand_dq_in,
    input  logic              nand_rb_n,
    input  logic [7:0]        wf_rdata,
    input  logic              wf_empty,
    output logic              wf_pop,
    input  logic              rf_full,
    output logic              rf_push,
    output logic [7:0]        rf_wdata
);
    seq_state_e state, nxt;

    logic [BYTE_W-1:0] c_code1, c_code2, wbyte, adr_byte;
    logic              c_wr, c_en2;
    logic [2:0]        adr_left, n_cap;
    logic [CNT_W-1:0]  dat_left;
    logic              bus_state, stall, run;
    logic              at_start, strobe_low, sample, fin;
    logic              rdy_run, rdy_ok;
    logic              accept, drive_cycle;

    assign accept = (state == ST_IDLE) && start;

    // requested address count, capped by page mode
    always_comb begin
        n_cap = addr_cycles;
        if (large_page) begin
            if (addr_cycles > 3'd5) n_cap = 3'd5;
        end else if (addr_cycles > 3'd4) begin
            n_cap = 3'd4;
        end
    end

    assign bus_state = (state == ST_CMD1) || (state == ST_ADDR) ||
                       (state == ST_CMD2) || (state == ST_DATA);
    assign stall     = (state == ST_DATA) && at_start && (c_wr ? wf_empty : rf_full);
    assign run       = bus_state && !stall;
    assign rdy_run   = (state == ST_RDY_PRE) || (state == ST_RDY_END);

    nand_strobe_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .at_start   (at_start),
        .strobe_low (strobe_low),
        .sample     (sample),
        .fin        (fin)
    );

    nand_ready_gate #(.BUSY_DLY(BUSY_DLY)) u_ready (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (rdy_run),
        .rb_n  (nand_rb_n),
        .ok    (rdy_ok)
    );

    nand_addr_shifter u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .shift ((state == ST_ADDR) && fin),
        .din   ({addr_ext, addr_word}),
        .dout  (adr_byte)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (en_cmd1)
                        nxt = ST_CMD1;
                    else if (en_addr && (n_cap != 3'd0))
                        nxt = ST_ADDR;
                    else
                        nxt = after_addr_phase(data_write, en_cmd2, data_count != '0);
                end
            end
            ST_CMD1: begin
                if (fin)
                    nxt = (adr_left != 3'd0) ? ST_ADDR
                                             : after_addr_phase(c_wr, c_en2, dat_left != '0);
            end
            ST_ADDR: begin
                if (fin && (adr_left == 3'd1))
                    nxt = after_addr_phase(c_wr, c_en2, dat_left != '0);
            end
            ST_CMD2: begin
                if (fin)
                    nxt = after_cmd2_phase(c_wr, dat_left != '0);
            end
            ST_RDY_PRE: begin
                if (rdy_ok)
                    nxt = ST_DATA;
            end
            ST_DATA: begin
                if (fin && (dat_left == CNT_W'(1)))
                    nxt = after_data_phase(c_wr, c_en2);
            end
            ST_RDY_END: begin
                if (rdy_ok)
                    nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // captured configuration, counters and done flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_code1  <= '0;
            c_code2  <= '0;
            c_wr     <= 1'b0;
            c_en2    <= 1'b0;
            adr_left <= '0;
            dat_left <= '0;
            wbyte    <= '0;
            done     <= 1'b0;
        end else begin
            if (accept) begin
                c_code1  <= cmd_codes[7:0];
                c_code2  <= cmd_codes[15:8];
                c_wr     <= data_write;
                c_en2    <= en_cmd2;
                adr_left <= en_addr ? n_cap : 3'd0;
                dat_left <= data_count;
                done     <= 1'b0;
            end else begin
                if ((state == ST_RDY_END) && rdy_ok)
                    done <= 1'b1;
                else if (done_clr)
                    done <= 1'b0;
                if ((state == ST_ADDR) && fin)
                    adr_left <= adr_left - 1'b1;
                if ((state == ST_DATA) && fin)
                    dat_left <= dat_left - 1'b1;
            end
            if (wf_pop)
                wbyte <= wf_rdata;
        end
    end

    // bus and FIFO outputs
    always_comb begin
        nand_ce_n   = !chip_en;
        nand_cle    = (state == ST_CMD1) || (state == ST_CMD2);
        nand_ale    = (state == ST_ADDR);
        drive_cycle = nand_cle || nand_ale || ((state == ST_DATA) && c_wr);
        nand_dq_oe  = drive_cycle;
        nand_we_n   = !(strobe_low && drive_cycle);
        nand_re_n   = !(strobe_low && (state == ST_DATA) && !c_wr);
        nand_dq_out = '0;
        unique case (state)
            ST_CMD1: nand_dq_out = c_code1;
            ST_CMD2: nand_dq_out = c_code2;
            ST_ADDR: nand_dq_out = adr_byte;
            ST_DATA: nand_dq_out = c_wr ? (at_start ? wf_rdata : wbyte) : '0;
            default: nand_dq_out = '0;
        endcase
        wf_pop   = (state == ST_DATA) && c_wr && at_start && !wf_empty;
        rf_push  = (state == ST_DATA) && !c_wr && sample;
        rf_wdata = nand_dq_in;
    end

endmodule

// File: rtl/nand_op_seq_chk.sv
module nand_op_seq_chk #(
    parameter int PULSE_CYC = 2
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic done_clr,
    input logic done,
    input logic nand_cle,
    input logic nand_ale,
    input logic nand_we_n,
    input logic nand_re_n,
    input logic nand_dq_oe,
    input logic nand_rb_n,
    input logic rf_push,
    input logic rf_full
);
    logic [7:0] we_low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            we_low_cnt <= '0;
        else if (nand_we_n)
            we_low_cnt <= '0;
        else if (we_low_cnt != 8'hFF)
            we_low_cnt <= we_low_cnt + 1'b1;
    end

    p_cle_ale_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    p_oe_on_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> nand_dq_oe);

    p_read_needs_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> nand_rb_n);

    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_clr && !start) |=> done);

    p_done_after_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(nand_rb_n));

    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));

    p_we_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_we_n) |-> (we_low_cnt == 8'(PULSE_CYC)));

    p_push_not_full_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rf_push |-> !rf_full);

endmodule

bind nand_op_seq nand_op_seq_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .done_clr   (done_clr),
    .done       (done),
    .nand_cle   (nand_cle),
    .nand_ale   (nand_ale),
    .nand_we_n  (nand_we_n),
    .nand_re_n  (nand_re_n),
    .nand_dq_oe (nand_dq_oe),
    .nand_rb_n  (nand_rb_n),
    .rf_push    (rf_push),
    .rf_full    (rf_full)
);

// File: tb/nand_op_seq_bench.sv
`timescale 1ns/1ps
module nand_op_seq_bench;
    localparam int PULSE = 2;
    localparam int BDLY  = 3;
    localparam int CW    = 12;
    localparam int K_CMD = 0, K_ADR = 1, K_WR = 2, K_RD = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 0, done_clr = 0;
    logic [15:0] cmd_codes = '0;
    logic en_cmd1 = 0, en_addr = 0, en_cmd2 = 0, data_write = 0;
    logic [2:0] addr_cycles = '0;
    logic large_page = 0;
    logic [31:0] addr_word = '0;
    logic [7:0] addr_ext = '0;
    logic [CW-1:0] data_count = '0;
    logic chip_en = 0;
    logic done, ce_n, cle, ale, we_n, re_n, dq_oe, wf_pop, rf_push;
    logic [7:0] dq_out, dq_in, wf_rdata, rf_wdata;
    logic rb_n = 1'b1;
    logic hold_empty = 0, rf_full = 0;
    logic [7:0] wq[$];
    logic wf_empty;

    int vectors = 0, miscompares = 0, cyc = 0;
    bit finished = 0, mon_en = 0;
    logic [9:0] exp_q[$];
    int busy_len = 0, busy_cnt = 0, rd_idx = 0, n_pushed = 0;
    int we_lo = 0, re_lo = 0, hi_cnt = 100, first_data_cyc = -1;
    logic prev_we = 1, prev_re = 1, prev_done = 0;
    logic [1:0] cap_kind = '0;
    logic [7:0] cap_val = '0, pushed = '0, m_code2 = '0;
    logic m_en2 = 0;

    always #2.5 clk = ~clk;

    assign wf_empty = hold_empty || (wq.size() == 0);
    assign wf_rdata = (wq.size() != 0) ? wq[0] : 8'h00;

    function automatic logic [7:0] rd_pat(input int i);
        return 8'(8'h5A + i * 13);
    endfunction
    assign dq_in = rd_pat(rd_idx);

    nand_op_seq #(.PULSE_CYC(PULSE), .BUSY_DLY(BDLY), .CNT_W(CW)) u_nand_op_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .done_clr(done_clr),
        .cmd_codes(cmd_codes), .en_cmd1(en_cmd1), .en_addr(en_addr), .en_cmd2(en_cmd2),
        .data_write(data_write), .addr_cycles(addr_cycles), .large_page(large_page),
        .addr_word(addr_word), .addr_ext(addr_ext), .data_count(data_count),
        .chip_en(chip_en), .done(done), .nand_ce_n(ce_n), .nand_cle(cle), .nand_ale(ale),
        .nand_we_n(we_n), .nand_re_n(re_n), .nand_dq_out(dq_out), .nand_dq_oe(dq_oe),
        .nand_dq_in(dq_in), .nand_rb_n(rb_n), .wf_rdata(wf_rdata), .wf_empty(wf_empty),
        .wf_pop(wf_pop), .rf_full(rf_full), .rf_push(rf_push), .rf_wdata(rf_wdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic take_event(input int kind, input logic [7:0] val, input string req);
        logic [9:0] e;
        if (exp_q.size() == 0) begin
            chk(0, req, "unexpected bus cycle", {kind[1:0], val}, 0);
        end else begin
            e = exp_q.pop_front();
            chk({kind[1:0], val} == e, req, "bus cycle kind/value", {kind[1:0], val}, e);
        end
    endtask

    // per-clock reference comparison
    logic pend_pop = 0;
    always @(negedge clk) begin
        cyc++;
        if (pend_pop && wq.size() != 0) void'(wq.pop_front());
        pend_pop = wf_pop;
        if (mon_en) begin
            chk(ce_n == !chip_en, "R10", "chip enable", ce_n, !chip_en);
            chk(!(we_n == 0 && re_n == 0), "R9", "strobes exclusive", {we_n, re_n}, 3);
            if (rf_push) begin
                chk(!rf_full, "R12", "push while full", rf_full, 0);
                pushed = rf_wdata;
                n_pushed++;
            end
            if (!we_n) begin
                we_lo++;
                if (we_lo == 1) chk(hi_cnt >= PULSE, "R9", "write strobe gap", hi_cnt, PULSE);
                cap_kind = cle ? 2'(K_CMD) : (ale ? 2'(K_ADR) : 2'(K_WR));
                cap_val = dq_out;
                if (cap_kind == 2'(K_WR) && we_lo == 1) begin
                    chk(!hold_empty, "R11", "write strobe while FIFO empty", 1, 0);
                    if (first_data_cyc < 0) first_data_cyc = cyc;
                end
            end else if (!prev_we) begin
                chk(we_lo == PULSE, "R9", "write strobe width", we_lo, PULSE);
                take_event(cap_kind, cap_val, cap_kind == 2'(K_CMD) ? "R1" :
                           cap_kind == 2'(K_ADR) ? "R3" : "R11");
                if (cap_kind == 2'(K_CMD) && m_en2 && cap_val == m_code2) busy_cnt = busy_len;
                we_lo = 0;
                hi_cnt = 0;
            end
            if (!re_n) begin
                re_lo++;
                if (re_lo == 1) begin
                    chk(hi_cnt >= PULSE, "R9", "read strobe gap", hi_cnt, PULSE);
                    if (first_data_cyc < 0) first_data_cyc = cyc;
                end
                chk(rb_n == 1'b1, "R7", "read strobe while busy", rb_n, 1);
            end else if (!prev_re) begin
                chk(re_lo == PULSE, "R9", "read strobe width", re_lo, PULSE);
                take_event(K_RD, pushed, "R12");
                rd_idx++;
                re_lo = 0;
                hi_cnt = 0;
            end
            if (we_n && re_n) hi_cnt++;
            if (done && !prev_done) begin
                chk(exp_q.size() == 0, "R8", "done before all cycles", exp_q.size(), 0);
                chk(busy_cnt == 0, "R8", "done while busy", busy_cnt, 0);
            end
            prev_we = we_n;
            prev_re = re_n;
            prev_done = done;
        end
        if (busy_cnt > 0) begin
            busy_cnt--;
            rb_n = 1'b0;
        end else begin
            rb_n = 1'b1;
        end
    end

    // set up an operation and the expected bus cycles
    task automatic setup_op(input logic [7:0] c1, input logic [7:0] c2, input bit e1,
                            input bit ea, input bit e2, input bit wr, input int na,
                            input bit lp, input logic [31:0] aw, input logic [7:0] ax,
                            input int cnt, input int blen);
        int ncap;
        logic [39:0] ab;
        @(negedge clk);
        cmd_codes = {c2, c1}; en_cmd1 = e1; en_addr = ea; en_cmd2 = e2;
        data_write = wr; addr_cycles = 3'(na); large_page = lp;
        addr_word = aw; addr_ext = ax; data_count = CW'(cnt);
        m_code2 = c2; m_en2 = e2; busy_len = blen;
        rd_idx = 0; n_pushed = 0; first_data_cyc = -1;
        ncap = lp ? (na > 5 ? 5 : na) : (na > 4 ? 4 : na);
        ab = {ax, aw};
        exp_q.delete();
        wq.delete();
        if (e1) exp_q.push_back({2'(K_CMD), c1});
        if (ea) for (int i = 0; i < ncap; i++) exp_q.push_back({2'(K_ADR), ab[8*i +: 8]});
        if (wr) begin
            for (int i = 0; i < cnt; i++) begin
                wq.push_back(8'(8'hC3 ^ (i * 29)));
                exp_q.push_back({2'(K_WR), 8'(8'hC3 ^ (i * 29))});
            end
            if (e2) exp_q.push_back({2'(K_CMD), c2});
        end else begin
            if (e2) exp_q.push_back({2'(K_CMD), c2});
            for (int i = 0; i < cnt; i++) exp_q.push_back({2'(K_RD), rd_pat(i)});
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
    endtask

    task automatic wait_done(input string req);
        int t = 0;
        while (!done && t < 6000) begin @(negedge clk); t++; end
        chk(done == 1'b1, req, "done reached", done, 1);
        chk(exp_q.size() == 0, req, "all cycles issued", exp_q.size(), 0);
    endtask

    task automatic run_op(input string req, input logic [7:0] c1, input logic [7:0] c2,
                          input bit e1, input bit ea, input bit e2, input bit wr,
                          input int na, input bit lp, input logic [31:0] aw,
                          input logic [7:0] ax, input int cnt, input int blen);
        setup_op(c1, c2, e1, ea, e2, wr, na, lp, aw, ax, cnt, blen);
        pulse_start();
        wait_done(req);
        if (!wr) chk(n_pushed == cnt, "R12", "read bytes pushed", n_pushed, cnt);
        if (wr) chk(wq.size() == 0, "R11", "write FIFO drained", wq.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        chip_en = 1;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state (R8, R9)
        chk(done == 0, "R8", "reset done", done, 0);
        chk(we_n == 1 && re_n == 1, "R9", "reset strobes", {we_n, re_n}, 3);
        chk(cle == 0 && ale == 0 && dq_oe == 0, "R1", "reset latches", {cle, ale, dq_oe}, 0);
        mon_en = 1;

        // R1 R6: command only, no data (reset-like)
        run_op("R6", 8'hFF, 8'h00, 1, 0, 0, 0, 0, 0, 32'h0, 8'h0, 0, 0);
        // R1 R6: status read of one byte
        run_op("R6", 8'h70, 8'h00, 1, 0, 0, 0, 0, 0, 32'h0, 8'h0, 1, 0);
        // R3: one address cycle, four reads (identify)
        run_op("R3", 8'h90, 8'h00, 1, 1, 0, 0, 1, 0, 32'h0000_0000, 8'h0, 4, 0);
        // R5 R2: erase form, three address bytes, busy at end
        run_op("R2", 8'h60, 8'hD0, 1, 1, 1, 0, 3, 0, 32'h0012_3456, 8'h0, 0, 25);
        // R5: program, data before second command
        run_op("R5", 8'h80, 8'h10, 1, 1, 1, 1, 4, 0, 32'hA1B2_C3D4, 8'h0, 8, 15);
        // R7 R5: large-page read with ready wait before data
        run_op("R7", 8'h00, 8'h30, 1, 1, 1, 0, 5, 1, 32'h7766_5544, 8'h99, 6, 30);
        // R4: cap at 4 in small-page mode, at 5 in large-page mode
        run_op("R4", 8'h00, 8'h30, 1, 1, 0, 0, 5, 0, 32'h0403_0201, 8'h05, 0, 0);
        run_op("R4", 8'h00, 8'h30, 1, 1, 0, 0, 7, 1, 32'h1413_1211, 8'h15, 0, 0);
        // R2: no first command, address then second command
        run_op("R2", 8'hEE, 8'h85, 0, 1, 1, 1, 2, 0, 32'h0000_BEEF, 8'h0, 0, 5);
        // R2: address phase disabled despite nonzero count
        run_op("R2", 8'h31, 8'h00, 1, 0, 0, 1, 3, 0, 32'hFFFF_FFFF, 8'h0, 3, 0);

        // R11: write stalls while FIFO reports empty
        setup_op(8'h80, 8'h10, 1, 1, 1, 1, 2, 0, 32'h0000_1234, 8'h0, 3, 4);
        hold_empty = 1;
        pulse_start();
        repeat (40) @(negedge clk);
        hold_empty = 0;
        begin
            int rel = cyc;
            wait_done("R11");
            chk(first_data_cyc > rel, "R11", "first write after release", first_data_cyc, rel);
        end

        // R12: read stalls while FIFO reports full
        setup_op(8'h00, 8'h30, 1, 1, 1, 0, 2, 0, 32'h0000_4321, 8'h0, 3, 6);
        rf_full = 1;
        pulse_start();
        repeat (60) @(negedge clk);
        rf_full = 0;
        begin
            int rel = cyc;
            wait_done("R12");
            chk(first_data_cyc > rel, "R12", "first read after release", first_data_cyc, rel);
        end

        // R8: start during an operation is ignored; inputs changed after capture
        setup_op(8'h60, 8'hD0, 1, 1, 1, 0, 3, 0, 32'h00AB_CDEF, 8'h0, 0, 10);
        pulse_start();
        repeat (6) @(negedge clk);
        cmd_codes = 16'h1122; addr_word = 32'h5555_5555; data_count = CW'(2);
        start = 1;
        @(negedge clk);
        start = 0;
        wait_done("R8");
        repeat (30) @(negedge clk);
        chk(exp_q.size() == 0 && we_n && re_n, "R8", "no cycles after done",
            exp_q.size(), 0);

        // R8: done holds, then clears on done_clr
        repeat (5) @(negedge clk);
        chk(done == 1, "R8", "done holds", done, 1);
        done_clr = 1;
        @(negedge clk);
        done_clr = 0;
        @(negedge clk);
        chk(done == 0, "R8", "done cleared", done, 0);

        // R10: chip enable follows control
        chip_en = 0;
        @(negedge clk);
        chk(ce_n == 1, "R10", "ce off", ce_n, 1);
        chip_en = 1;
        @(negedge clk);
        chk(ce_n == 0, "R10", "ce on", ce_n, 0);

        repeat (5) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule